// File: doc/BRIEF.md
# HDLC Receive Bit Processor

This block is the bit-level front end of a synchronous bit-oriented serial receiver. It takes a serial stream that has already been recovered, one bit per cycle in which `bit_vld` is high, undoes the NRZI line coding, and strips the zeros the transmitter stuffed after runs of five ones. It recognises the control patterns that can appear on the line and reports each one with a single-cycle pulse. The five patterns are the frame delimiter (flag), go-ahead, early go-ahead, abort and the eight-zero loop shutoff command. Data bits between flags are packed into 8-bit bytes.

Delimiter bits must never leak into the byte stream. A bit only becomes certain to be data once it is clear it does not start a delimiter. For this reason, data bits pass through a short holding line before they reach the byte packer. The holding line is exactly as deep as the longest run a delimiter can share with data: a zero plus five ones. The result is that every byte of a frame has left the block before the closing flag is reported. Frame parsing, check-sequence verification and clock recovery belong to the blocks around this one.

Top module: `hdlc_rx_bitproc`

## Requirements
- R1: Line decoding. After reset the reference line level is 1. A line bit accepted with `bit_vld` decodes to 1 when it equals the previously accepted line bit, and to 0 when it differs. While `bit_vld` is low, the line value is ignored and all outputs stay low.
- R2: All pulses and `byte_vld` are registered. Each one becomes visible after the rising edge that accepts the bit completing the event, and each lasts exactly one cycle.
- R3: The decoded sequence 0,1,1,1,1,1,1,0 (oldest first) raises `flag_p` on its last bit and synchronises byte packing. The next data bit becomes bit 0 of a new byte. A flag never coincides with an abort.
- R4: A decoded 0 followed by seven 1s raises `goahead_p` on the seventh 1.
- R5: The seventh consecutive decoded 1 raises `abort_p`, once per run of ones. Any partial byte is dropped, and no byte is delivered until the next flag.
- R6: Six decoded 1s followed by a 0 raise `early_ga_p`, whether or not a 0 came before the run. Every flag therefore also raises it.
- R7: A decoded 0 that follows exactly five 1s is a stuffed bit. It is discarded and does not enter a byte.
- R8: A 3-bit counter counts consecutive decoded 0s and is cleared by any 1. `shutoff_p` pulses on every eighth consecutive 0.
- R9: Bytes are packed least significant bit first. Each byte appears on `byte_data` with a one-cycle `byte_vld`, on the edge that accepts the sixth data bit after the byte's last bit. All bytes of a frame are out before its closing flag, and a byte never coincides with a flag.
- R10: Bits received after reset or after an abort, before the first flag, produce no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | Line bit strobe; `line_bit` is accepted when high |
| line_bit | input | 1 | NRZI coded serial line bit |
| byte_data | output | 8 | Last assembled byte, LSB received first |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |
| flag_p | output | 1 | Flag detected |
| goahead_p | output | 1 | Go-ahead detected |
| early_ga_p | output | 1 | Early go-ahead detected |
| abort_p | output | 1 | Abort detected |
| shutoff_p | output | 1 | Eight-zero shutoff detected |

## Verification
Every pattern pulse is due right after the edge that accepts the completing bit. The bench drives each bit at a falling edge and samples one time unit after the next rising edge, so each pulse is checked against the exact bit that completes it. Bytes are due on the sixth data bit after their last bit, which can fall inside the closing flag. Frames are therefore judged by the ordered list of bytes collected at those sample points, read once the closing flag has gone through. Idle cycles with line activity are inserted mid-frame, and every one of them is checked for silent outputs.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;
  // Run of ones after which a zero is a stuffed bit.
  localparam int unsigned STUFF_RUN = 5;
  // Run of ones that forms an abort.
  localparam int unsigned ABORT_RUN = 7;
  // Delimiter windows, oldest bit in the MSB.
  localparam int unsigned WIN_W = 8;
  localparam logic [WIN_W-1:0] FLAG_PAT = 8'b0111_1110;
  localparam logic [WIN_W-1:0] GA_PAT   = 8'b0111_1111;
  localparam logic [WIN_W-2:0] EGA_PAT  = 7'b111_1110;
  // Data bits that a delimiter may share before it is recognisable.
  localparam int unsigned HOLD_DEPTH = STUFF_RUN + 1;
  // Width of the consecutive-zero counter (wraps every 2**SHUT_W zeros).
  localparam int unsigned SHUT_W = 3;

  typedef struct packed {
    logic flag;
    logic ga;
    logic ega;
    logic abort;
    logic shut;
  } evt_t;
endpackage

// File: rtl/hdlc_nrzi_dec.sv
`timescale 1ns/1ps
module hdlc_nrzi_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic line_bit,
  output logic dec_vld,
  output logic dec_bit
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (bit_vld) begin
      prev_d = line_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  // No transition -> 1, transition -> 0.
  assign dec_bit = ~(line_bit ^ prev_q);
  assign dec_vld = bit_vld;
endmodule

// File: rtl/hdlc_pattern_det.sv
`timescale 1ns/1ps
module hdlc_pattern_det
  import hdlc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic din,
  output logic data_ev,
  output logic desync_ev,
  output evt_t evt
);
  localparam int unsigned ONES_W = $clog2(ABORT_RUN + 1);
  localparam logic [ONES_W-1:0] ONES_SAT   = ONES_W'(ABORT_RUN);
  localparam logic [ONES_W-1:0] ONES_ABORT = ONES_W'(ABORT_RUN - 1);
  localparam logic [ONES_W-1:0] ONES_STUFF = ONES_W'(STUFF_RUN);

  logic [WIN_W-2:0]  hist_q, hist_d;
  logic [ONES_W-1:0] ones_q, ones_d;
  logic [SHUT_W-1:0] zeros_q, zeros_d;
  logic [WIN_W-1:0]  win;

  always_comb begin
    win     = {hist_q, din};
    hist_d  = hist_q;
    ones_d  = ones_q;
    zeros_d = zeros_q;
    if (vld) begin
      hist_d = {hist_q[WIN_W-3:0], din};
      if (din) begin
        ones_d  = (ones_q == ONES_SAT) ? ones_q : ones_q + 1'b1;
        zeros_d = '0;
      end else begin
        ones_d  = '0;
        zeros_d = zeros_q + 1'b1;
      end
    end
  end

  always_comb begin
    evt.flag  = vld && (win == FLAG_PAT);
    evt.ga    = vld && (win == GA_PAT);
    evt.ega   = vld && (win[WIN_W-2:0] == EGA_PAT);
    evt.abort = vld && din && (ones_q == ONES_ABORT);
    evt.shut  = vld && !din && (zeros_q == '1);
    // Below the stuffing run every bit is data; at or above it a 0 is
    // stuffed or a terminator and a 1 breaks any frame.
    data_ev   = vld && (ones_q < ONES_STUFF);
    desync_ev = vld && din && (ones_q >= ONES_STUFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      ones_q  <= '0;
      zeros_q <= '0;
    end else begin
      hist_q  <= hist_d;
      ones_q  <= ones_d;
      zeros_q <= zeros_d;
    end
  end
endmodule

// File: rtl/hdlc_byte_asm.sv
`timescale 1ns/1ps
module hdlc_byte_asm #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HOLD   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              din,
  input  logic              sync_set,
  input  logic              sync_clr,
  output logic [DATA_W-1:0] byte_q,
  output logic              bvld_q
);
  localparam int unsigned BCNT_W = $clog2(DATA_W);
  localparam int unsigned HCNT_W = $clog2(HOLD + 1);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(DATA_W - 1);
  localparam logic [HCNT_W-1:0] HCNT_FULL = HCNT_W'(HOLD);

  logic              synced_q, synced_d;
  logic [HOLD-1:0]   hold_q, hold_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [DATA_W-1:0] byte_d;
  logic              bvld_d;
  logic              out_bit;

  assign out_bit = hold_q[HOLD-1];

  always_comb begin
    synced_d = synced_q;
    hold_d   = hold_q;
    hcnt_d   = hcnt_q;
    sh_d     = sh_q;
    bcnt_d   = bcnt_q;
    byte_d   = byte_q;
    bvld_d   = 1'b0;
    if (sync_set) begin
      synced_d = 1'b1;
      hcnt_d   = '0;
      bcnt_d   = '0;
    end else if (sync_clr) begin
      synced_d = 1'b0;
      hcnt_d   = '0;
      bcnt_d   = '0;
    end else if (push && synced_q) begin
      hold_d = {hold_q[HOLD-2:0], din};
      if (hcnt_q == HCNT_FULL) begin
        sh_d = {out_bit, sh_q[DATA_W-1:1]};
        if (bcnt_q == BCNT_LAST) begin
          bcnt_d = '0;
          bvld_d = 1'b1;
          byte_d = {out_bit, sh_q[DATA_W-1:1]};
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced_q <= 1'b0;
      hold_q   <= '0;
      hcnt_q   <= '0;
      sh_q     <= '0;
      bcnt_q   <= '0;
      byte_q   <= '0;
      bvld_q   <= 1'b0;
    end else begin
      synced_q <= synced_d;
      hold_q   <= hold_d;
      hcnt_q   <= hcnt_d;
      sh_q     <= sh_d;
      bcnt_q   <= bcnt_d;
      byte_q   <= byte_d;
      bvld_q   <= bvld_d;
    end
  end
endmodule

// File: rtl/hdlc_rx_bitproc.sv
`timescale 1ns/1ps
module hdlc_rx_bitproc
  import hdlc_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              line_bit,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              flag_p,
  output logic              goahead_p,
  output logic              early_ga_p,
  output logic              abort_p,
  output logic              shutoff_p
);
  localparam int unsigned RS_STAGES = 2;

  logic [RS_STAGES-1:0] rs_q;
  logic                 core_rst_n;
  logic                 dec_vld, dec_bit;
  logic                 data_ev, desync_ev;
  evt_t                 evt, evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RS_STAGES-2:0], 1'b1};
    end
  end
  assign core_rst_n = rs_q[RS_STAGES-1];

  hdlc_nrzi_dec u_nrzi (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .bit_vld  (bit_vld),
    .line_bit (line_bit),
    .dec_vld  (dec_vld),
    .dec_bit  (dec_bit)
  );

  hdlc_pattern_det u_det (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .vld       (dec_vld),
    .din       (dec_bit),
    .data_ev   (data_ev),
    .desync_ev (desync_ev),
    .evt       (evt)
  );

  hdlc_byte_asm #(
    .DATA_W (DATA_W),
    .HOLD   (HOLD_DEPTH)
  ) u_asm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .push     (data_ev),
    .din      (dec_bit),
    .sync_set (evt.flag),
    .sync_clr (desync_ev),
    .byte_q   (byte_data),
    .bvld_q   (byte_vld)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt;
    end
  end

  assign flag_p     = evt_q.flag;
  assign goahead_p  = evt_q.ga;
  assign early_ga_p = evt_q.ega;
  assign abort_p    = evt_q.abort;
  assign shutoff_p  = evt_q.shut;
endmodule

// File: rtl/hdlc_rx_bitproc_chk.sv
`timescale 1ns/1ps
module hdlc_rx_bitproc_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic byte_vld,
  input logic flag_p,
  input logic goahead_p,
  input logic early_ga_p,
  input logic abort_p,
  input logic shutoff_p
);
  AST_OUT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld || flag_p || goahead_p || early_ga_p || abort_p || shutoff_p) |-> $past(bit_vld)); // R2
  AST_FLAG_NOT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_p, abort_p})); // R3
  AST_GA_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    goahead_p |-> abort_p); // R4
  AST_FLAG_WITH_EGA: assert property (@(posedge clk) disable iff (!rst_n)
    flag_p |-> early_ga_p); // R6
  AST_SHUT_NO_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    shutoff_p |-> !(abort_p || goahead_p)); // R8
  AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R9
  AST_BYTE_NOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_p |-> !byte_vld); // R9
endmodule

bind hdlc_rx_bitproc hdlc_rx_bitproc_chk u_chk (.*);

// File: tb/sim_hdlc_rx_bitproc.sv
`timescale 1ns/1ps
module sim_hdlc_rx_bitproc;
  localparam int unsigned WD_CYCLES = 20000;
  localparam int unsigned NVEC = 5;
  // Each entry: {first byte, second byte} of a two-byte frame.
  localparam logic [15:0] VEC [NVEC] = '{16'hA53C, 16'hFF7E, 16'h001F, 16'hF8BF, 16'h7C3E};

  logic       clk, rst_n, bit_vld, line_bit;
  logic [7:0] byte_data;
  logic       byte_vld, flag_p, goahead_p, early_ga_p, abort_p, shutoff_p;

  int n_tests, n_fail;
  int cnt_flag, cnt_ga, cnt_ega, cnt_abort, cnt_shut;
  logic line_lvl;
  int ones_run;
  logic [7:0] rxq[$];
  logic s_flag, s_ga, s_ega, s_abort, s_shut;

  hdlc_rx_bitproc u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_bit(line_bit),
    .byte_data(byte_data), .byte_vld(byte_vld), .flag_p(flag_p),
    .goahead_p(goahead_p), .early_ga_p(early_ga_p), .abort_p(abort_p),
    .shutoff_p(shutoff_p)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    cnt_flag = 0; cnt_ga = 0; cnt_ega = 0; cnt_abort = 0; cnt_shut = 0;
    rxq.delete();
  endtask

  // Send one decoded bit NRZI coded; sample outputs after the accepting edge.
  task automatic send_dec(input logic b);
    @(negedge clk);
    if (!b) line_lvl = ~line_lvl;
    line_bit = line_lvl;
    bit_vld  = 1'b1;
    @(posedge clk);
    #1;
    bit_vld = 1'b0;
    s_flag = flag_p; s_ga = goahead_p; s_ega = early_ga_p;
    s_abort = abort_p; s_shut = shutoff_p;
    cnt_flag += int'(flag_p); cnt_ga += int'(goahead_p); cnt_ega += int'(early_ga_p);
    cnt_abort += int'(abort_p); cnt_shut += int'(shutoff_p);
    if (byte_vld) rxq.push_back(byte_data);
  endtask

  task automatic send_flag();
    for (int i = 7; i >= 0; i--) send_dec(hdlc_rx_pkg::FLAG_PAT[i]);
    ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_dec(b[i]);
      if (b[i]) begin
        ones_run++;
        if (ones_run == 5) begin
          send_dec(1'b0);
          ones_run = 0;
        end
      end else begin
        ones_run = 0;
      end
    end
  endtask

  // R1: idle cycles with a busy line must leave every output low.
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_bit = ~line_bit;
      bit_vld  = 1'b0;
      @(posedge clk);
      #1;
      chk("R1", "outputs during idle", int'({byte_vld, flag_p, goahead_p, early_ga_p, abort_p, shutoff_p}), 0);
    end
    line_bit = line_lvl;
  endtask

  initial begin
    #(WD_CYCLES * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; ones_run = 0;
    rst_n = 1'b0; bit_vld = 1'b0; line_bit = 1'b1; line_lvl = 1'b1;
    clr();
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R2", "reset outputs", int'({byte_vld, flag_p, goahead_p, early_ga_p, abort_p, shutoff_p}), 0);

    // R10: data with no flag after reset yields nothing
    send_byte(8'h55); send_byte(8'hAA); send_byte(8'h33);
    chk("R10", "bytes before first flag", rxq.size(), 0);

    // Table of two-byte frames, R3 R7 R9 R1
    for (int v = 0; v < NVEC; v++) begin
      clr();
      send_flag();
      send_byte(VEC[v][15:8]);
      gap(3);
      send_byte(VEC[v][7:0]);
      send_flag();
      chk("R9", "frame byte count", rxq.size(), 2);
      if (rxq.size() == 2) begin
        chk("R9", "first byte (LSB first, R7 destuffed)", rxq[0], VEC[v][15:8]);
        chk("R7", "second byte", rxq[1], VEC[v][7:0]);
      end
      chk("R3", "flags per frame", cnt_flag, 2);
      chk("R6", "early go-ahead per frame", cnt_ega, 2);
    end

    // Abort in the middle of a byte: R5
    clr();
    send_flag();
    send_dec(1'b0); send_dec(1'b1); send_dec(1'b0);
    for (int i = 0; i < 7; i++) begin
      send_dec(1'b1);
      if (i == 5) chk("R5", "abort before 7th one", s_abort, 0);
    end
    chk("R5", "abort on 7th one", s_abort, 1);
    chk("R4", "go-ahead with 0 before run", s_ga, 1);
    for (int i = 0; i < 16; i++) send_dec(i[0]);
    chk("R5", "no byte after abort", rxq.size(), 0);

    // Go-ahead: R4
    clr();
    send_dec(1'b0);
    for (int i = 0; i < 7; i++) begin
      send_dec(1'b1);
      if (i == 5) chk("R4", "go-ahead after six ones", s_ga, 0);
    end
    chk("R4", "go-ahead on seventh one", s_ga, 1);
    send_dec(1'b1);
    chk("R5", "abort once per run", s_abort, 0);
    // Early go-ahead without a leading 0: R6
    send_dec(1'b0);
    chk("R6", "early go-ahead", s_ega, 1);
    chk("R3", "no flag when run exceeds six", s_flag, 0);

    // Shutoff: R8
    clr();
    send_dec(1'b1);
    for (int i = 0; i < 16; i++) begin
      send_dec(1'b0);
      if (i == 6) chk("R8", "no shutoff at seventh zero", s_shut, 0);
      if (i == 7) chk("R8", "shutoff at eighth zero", s_shut, 1);
      if (i == 15) chk("R8", "shutoff at sixteenth zero", s_shut, 1);
    end
    chk("R8", "shutoff count", cnt_shut, 2);
    send_dec(1'b1);
    for (int i = 0; i < 4; i++) send_dec(1'b0);
    chk("R8", "counter cleared by one", cnt_shut, 2);

    // Flag not on a byte boundary: R3
    clr();
    send_dec(1'b1); send_dec(1'b1); send_dec(1'b0);
    send_flag();
    send_byte(8'h5A); send_byte(8'h81);
    send_flag();
    chk("R3", "unaligned frame bytes", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R3", "unaligned byte 0", rxq[0], 8'h5A);
      chk("R3", "unaligned byte 1", rxq[1], 8'h81);
    end

    // Back-to-back flags: R3
    clr();
    send_flag(); send_flag(); send_flag();
    chk("R3", "back-to-back flag count", cnt_flag, 3);
    chk("R9", "no byte from flags", rxq.size(), 0);
    send_byte(8'hC3);
    send_flag();
    chk("R9", "byte after flags", rxq.size(), 1);
    if (rxq.size() == 1) chk("R9", "byte value", rxq[0], 8'hC3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule